// File: doc/BRIEF.md
# Hart-Side Debug Memory Slave

This block is the memory a halted hart executes from while under external debug control. The hart fetches from a small address window holding four regions: one entry word per hart, a handful of generated code words, a program buffer that the hart may also load from and store to, and one exception word per hart. A command engine elsewhere writes instructions into the entry, code and exception words through a dedicated patch port, and it reads back two single-cycle pulses: one that says the running command has finished and one that says the hart trapped while running debug code.

Everything the block reports is inferred from the hart's fetch pattern. A fetch from an entry word marks that hart as halted. If, at that moment, the entry word of the currently selected hart holds a jump-to-self (`0x0000006F`), the hart is back in its idle loop and the command is finished. After an entry word has been fetched, the first access anywhere outside the entry region replaces the selected hart's entry word with a pending follow-up instruction, so a command can be chained through two stages; the pending value then falls back to the jump-to-self.

Hart accesses are single words on a simple request/response interface: the response, with read data or an error, arrives exactly one cycle after the request.

Top module: `dbgmem_slave`

## Requirements
- R1: After reset every entry word reads `0x0000006F`, every code, program-buffer and exception word reads zero, and all `halted` bits are zero.
- R2: A read of entry word N returns its contents and sets `halted[N]` from the following cycle; `halted` bits are cleared only by reset.
- R3: `busy_clr` pulses for one cycle, together with the response, after an entry-region read made while the entry word of `sel_hart` held `0x0000006F`; otherwise it stays low.
- R4: Once any entry word has been read, the next request whose address is outside the entry region writes the pending word into the entry word of `sel_hart`; the pending word then becomes `0x0000006F` and later outside requests change nothing until another entry read.
- R5: A read of exception word N returns its contents; `exc_err` pulses with the response when `err_none` was high in the request cycle and stays low when it was low.
- R6: The program buffer accepts reads and writes; on a write, `be[k]` enables byte lane k, bits 8k+7:8k, and a disabled lane keeps its old value.
- R7: A write to the entry, code or exception region returns `rsp_err` and leaves the word unchanged.
- R8: An address outside all four regions, or with `addr[1:0]` nonzero, returns `rsp_err` with `rsp_rdata` zero. The default map places entry words at 0x100, code at 0x200, program buffer at 0x300 and exception words at 0x400, four bytes per word.
- R9: `patch_we` writes `patch_data` into word `patch_idx` of the region chosen by `patch_tgt` (0 entry, 1 code, 2 exception, 3 none); when it targets the same entry word as a same-cycle R4 rewrite, the patch value is kept.
- R10: `pend_we` loads `pend_data` as the pending word; if it coincides with an R4 rewrite, the old pending word goes to the entry word and the new one stays pending.
- R11: `rsp_valid` is high exactly one cycle after each request, and read data reflects the contents before any update made in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Hart access request, one word |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address of the word |
| wdata | input | 32 | Write data |
| be | input | 4 | Byte lane enables for writes |
| rsp_valid | output | 1 | Response strobe, one cycle after `req` |
| rsp_rdata | output | 32 | Read data (zero on write or error) |
| rsp_err | output | 1 | Error response |
| sel_hart | input | HART_W | Hart the running command addresses |
| err_none | input | 1 | Engine has no error recorded yet |
| patch_we | input | 1 | Patch write strobe |
| patch_tgt | input | 2 | Patch target region: 0 entry, 1 code, 2 exception, 3 none |
| patch_idx | input | IDX_W | Word index within the target region |
| patch_data | input | 32 | Patch word |
| pend_we | input | 1 | Load the pending follow-up word |
| pend_data | input | 32 | Pending follow-up word |
| halted | output | NUM_HARTS | Per-hart halted flags |
| busy_clr | output | 1 | Command-finished pulse |
| exc_err | output | 1 | Exception-during-debug pulse |

## Verification
A stale or wrong executed-mark shows at the ports on the next outside access: the selected entry word either fails to take the pending value or takes it twice, and the following entry read returns the wrong instruction and raises or drops `busy_clr` one response later. A halted flag that is set on the wrong hart is visible on `halted` the cycle after the fetch. Because every read returns pre-update contents, a patch or rewrite that lands on the wrong word shows on the first read of that word, so a random mix of fetches, patches and pending loads compared against a cycle model exposes ordering faults within a few requests.

// File: rtl/dbgmem_pkg.sv
// Shared constants and types for the hart-side debug memory.
// Assumes 32-bit instruction words.
package dbgmem_pkg;
    // Encoding of an unconditional jump to its own address.
    localparam logic [31:0] JAL_SELF = 32'h0000_006F;

    typedef enum logic [2:0] {
        RG_NONE  = 3'd0,
        RG_ENTRY = 3'd1,
        RG_CODE  = 3'd2,
        RG_PBUF  = 3'd3,
        RG_EXC   = 3'd4
    } region_e;

    typedef enum logic [1:0] {
        PT_ENTRY = 2'd0,
        PT_CODE  = 2'd1,
        PT_EXC   = 2'd2,
        PT_NONE  = 2'd3
    } patch_tgt_e;
endpackage

// File: rtl/dbgmem_decode.sv
// Address decoder: maps a byte address onto one of the four regions and a
// word index inside it. Misaligned or unmapped addresses decode to RG_NONE.
// Assumes region bases are word aligned and regions do not overlap.
module dbgmem_decode
    import dbgmem_pkg::*;
#(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned IDX_W      = 3,
    parameter int unsigned NUM_HARTS  = 4,
    parameter int unsigned CODE_WORDS = 2,
    parameter int unsigned PBUF_WORDS = 8,
    parameter int unsigned ENTRY_BASE = 'h100,
    parameter int unsigned CODE_BASE  = 'h200,
    parameter int unsigned PBUF_BASE  = 'h300,
    parameter int unsigned EXC_BASE   = 'h400
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [IDX_W-1:0]  idx
);
    localparam int NRG = 4;
    localparam logic [ADDR_W:0] LO [NRG] = '{
        (ADDR_W+1)'(ENTRY_BASE), (ADDR_W+1)'(CODE_BASE),
        (ADDR_W+1)'(PBUF_BASE),  (ADDR_W+1)'(EXC_BASE)};
    localparam logic [ADDR_W:0] SPAN [NRG] = '{
        (ADDR_W+1)'(4*NUM_HARTS), (ADDR_W+1)'(4*CODE_WORDS),
        (ADDR_W+1)'(4*PBUF_WORDS), (ADDR_W+1)'(4*NUM_HARTS)};
    localparam region_e RG [NRG] = '{RG_ENTRY, RG_CODE, RG_PBUF, RG_EXC};

    logic [ADDR_W:0] addr_x;
    logic [ADDR_W:0] off;

    assign addr_x = {1'b0, addr};

    // Pick the region whose window holds an aligned address.
    always_comb begin
        region = RG_NONE;
        idx    = '0;
        off    = '0;
        for (int r = 0; r < NRG; r++) begin
            if (addr[1:0] == 2'b00 && addr_x >= LO[r] &&
                (addr_x - LO[r]) < SPAN[r]) begin
                off    = addr_x - LO[r];
                region = RG[r];
                idx    = off[IDX_W+1:2];
            end
        end
    end
endmodule

// File: rtl/dbgmem_bank.sv
// Word bank with two write ports. Port A (full word) wins over port B
// (byte-enabled) when both address the same word. All words are exposed
// so the parent can build its own read multiplexers.
// Assumes indices at or above WORDS are simply not matched.
module dbgmem_bank #(
    parameter int unsigned WORDS    = 4,
    parameter int unsigned IDX_W    = 3,
    parameter logic [31:0] RST_WORD = 32'h0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   a_we,
    input  logic [IDX_W-1:0]       a_idx,
    input  logic [31:0]            a_data,
    input  logic                   b_we,
    input  logic [IDX_W-1:0]       b_idx,
    input  logic [3:0]             b_be,
    input  logic [31:0]            b_data,
    output logic [WORDS-1:0][31:0] words_o
);
    logic [31:0] mem_q [WORDS];

    // Reset every word, then apply port A before port B per word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= RST_WORD;
        end else begin
            for (int i = 0; i < WORDS; i++) begin
                if (a_we && a_idx == IDX_W'(i)) begin
                    mem_q[i] <= a_data;
                end else if (b_we && b_idx == IDX_W'(i)) begin
                    for (int k = 0; k < 4; k++) begin
                        if (b_be[k]) mem_q[i][8*k +: 8] <= b_data[8*k +: 8];
                    end
                end
            end
        end
    end

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        assign words_o[g] = mem_q[g];

        // R9: a same-cycle port A write overrides a port B write.
        assert_patch_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (a_we && b_we && a_idx == IDX_W'(g) && b_idx == IDX_W'(g))
            |=> (words_o[g] == $past(a_data)));
    end
endmodule

// File: rtl/dbgmem_track.sv
// Fetch-pattern tracker: halted flags, executed mark, pending follow-up
// word and the busy-clear / exception pulses. The pulses are registered so
// they line up with the response to the triggering request.
// Assumes entry_rd and other_acc are never high together.
module dbgmem_track
    import dbgmem_pkg::*;
#(
    parameter int unsigned NUM_HARTS = 4,
    parameter int unsigned IDX_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 entry_rd,
    input  logic [IDX_W-1:0]     entry_idx,
    input  logic                 sel_is_self,
    input  logic                 exc_rd,
    input  logic                 err_none,
    input  logic                 other_acc,
    input  logic                 pend_we,
    input  logic [31:0]          pend_data,
    output logic [NUM_HARTS-1:0] halted,
    output logic                 busy_clr,
    output logic                 exc_err,
    output logic                 lazy_we,
    output logic [31:0]          lazy_data
);
    logic [NUM_HARTS-1:0] halted_q;
    logic                 mark_q;
    logic [31:0]          pend_q;
    logic                 busy_q;
    logic                 exc_q;

    assign lazy_we   = other_acc && mark_q;
    assign lazy_data = pend_q;
    assign halted    = halted_q;
    assign busy_clr  = busy_q;
    assign exc_err   = exc_q;

    // Sticky halted flag per hart, set by a fetch of its entry word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halted_q <= '0;
        end else begin
            for (int h = 0; h < NUM_HARTS; h++) begin
                if (entry_rd && entry_idx == IDX_W'(h)) halted_q[h] <= 1'b1;
            end
        end
    end

    // Executed mark and pending follow-up word; a new pending load wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mark_q <= 1'b0;
            pend_q <= JAL_SELF;
        end else begin
            if (entry_rd)     mark_q <= 1'b1;
            else if (lazy_we) mark_q <= 1'b0;
            if (pend_we)      pend_q <= pend_data;
            else if (lazy_we) pend_q <= JAL_SELF;
        end
    end

    // One-cycle completion and exception pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            exc_q  <= 1'b0;
        end else begin
            busy_q <= entry_rd && sel_is_self;
            exc_q  <= exc_rd && err_none;
        end
    end

    // R2: halted flags never fall outside reset.
    assert_halted_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((halted & $past(halted)) == $past(halted)));

    // R4: a rewrite consumes the mark, so two in a row cannot occur.
    assert_repatch_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lazy_we |=> !lazy_we);
endmodule

// File: rtl/dbgmem_slave.sv
// Hart-side debug memory slave. Decodes hart accesses into entry, code,
// program-buffer and exception regions, registers a one-cycle-late
// response, and hosts the patch port and fetch-pattern tracking.
// Assumes power-of-two NUM_HARTS so every sel_hart value names a hart.
module dbgmem_slave
    import dbgmem_pkg::*;
#(
    parameter int unsigned NUM_HARTS  = 4,
    parameter int unsigned CODE_WORDS = 2,
    parameter int unsigned PBUF_WORDS = 8,
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned ENTRY_BASE = 'h100,
    parameter int unsigned CODE_BASE  = 'h200,
    parameter int unsigned PBUF_BASE  = 'h300,
    parameter int unsigned EXC_BASE   = 'h400,
    localparam int unsigned MAXW      = (NUM_HARTS > CODE_WORDS)
        ? ((NUM_HARTS > PBUF_WORDS) ? NUM_HARTS : PBUF_WORDS)
        : ((CODE_WORDS > PBUF_WORDS) ? CODE_WORDS : PBUF_WORDS),
    localparam int unsigned IDX_W     = (MAXW > 1) ? $clog2(MAXW) : 1,
    localparam int unsigned HART_W    = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [31:0]          wdata,
    input  logic [3:0]           be,
    output logic                 rsp_valid,
    output logic [31:0]          rsp_rdata,
    output logic                 rsp_err,
    input  logic [HART_W-1:0]    sel_hart,
    input  logic                 err_none,
    input  logic                 patch_we,
    input  logic [1:0]           patch_tgt,
    input  logic [IDX_W-1:0]     patch_idx,
    input  logic [31:0]          patch_data,
    input  logic                 pend_we,
    input  logic [31:0]          pend_data,
    output logic [NUM_HARTS-1:0] halted,
    output logic                 busy_clr,
    output logic                 exc_err
);
    region_e                    dec_rg;
    logic [IDX_W-1:0]           dec_idx;
    logic [NUM_HARTS-1:0][31:0] ent_w;
    logic [CODE_WORDS-1:0][31:0] code_w;
    logic [PBUF_WORDS-1:0][31:0] pbuf_w;
    logic [NUM_HARTS-1:0][31:0] exc_w;
    logic                       ent_rd, exc_rd, other_acc, pb_we, acc_err;
    logic                       lazy_we;
    logic [31:0]                lazy_data;
    logic [31:0]                sel_word, rd_word;

    dbgmem_decode #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .NUM_HARTS(NUM_HARTS),
        .CODE_WORDS(CODE_WORDS), .PBUF_WORDS(PBUF_WORDS),
        .ENTRY_BASE(ENTRY_BASE), .CODE_BASE(CODE_BASE),
        .PBUF_BASE(PBUF_BASE), .EXC_BASE(EXC_BASE)
    ) u_dec (
        .addr(addr), .region(dec_rg), .idx(dec_idx)
    );

    assign ent_rd    = req && !we && dec_rg == RG_ENTRY;
    assign exc_rd    = req && !we && dec_rg == RG_EXC;
    assign other_acc = req && dec_rg != RG_ENTRY;
    assign pb_we     = req && we && dec_rg == RG_PBUF;
    assign acc_err   = dec_rg == RG_NONE || (we && dec_rg != RG_PBUF);

    dbgmem_bank #(.WORDS(NUM_HARTS), .IDX_W(IDX_W), .RST_WORD(JAL_SELF)) u_entry (
        .clk(clk), .rst_n(rst_n),
        .a_we(patch_we && patch_tgt == PT_ENTRY), .a_idx(patch_idx), .a_data(patch_data),
        .b_we(lazy_we), .b_idx(IDX_W'(sel_hart)), .b_be(4'hF), .b_data(lazy_data),
        .words_o(ent_w)
    );

    dbgmem_bank #(.WORDS(CODE_WORDS), .IDX_W(IDX_W), .RST_WORD(32'h0)) u_code (
        .clk(clk), .rst_n(rst_n),
        .a_we(patch_we && patch_tgt == PT_CODE), .a_idx(patch_idx), .a_data(patch_data),
        .b_we(1'b0), .b_idx('0), .b_be(4'h0), .b_data(32'h0),
        .words_o(code_w)
    );

    dbgmem_bank #(.WORDS(PBUF_WORDS), .IDX_W(IDX_W), .RST_WORD(32'h0)) u_pbuf (
        .clk(clk), .rst_n(rst_n),
        .a_we(1'b0), .a_idx('0), .a_data(32'h0),
        .b_we(pb_we), .b_idx(dec_idx), .b_be(be), .b_data(wdata),
        .words_o(pbuf_w)
    );

    dbgmem_bank #(.WORDS(NUM_HARTS), .IDX_W(IDX_W), .RST_WORD(32'h0)) u_exc (
        .clk(clk), .rst_n(rst_n),
        .a_we(patch_we && patch_tgt == PT_EXC), .a_idx(patch_idx), .a_data(patch_data),
        .b_we(1'b0), .b_idx('0), .b_be(4'h0), .b_data(32'h0),
        .words_o(exc_w)
    );

    // Entry word of the selected hart, for completion detection.
    always_comb begin
        sel_word = 32'h0;
        for (int h = 0; h < NUM_HARTS; h++) begin
            if (sel_hart == HART_W'(h)) sel_word = ent_w[h];
        end
    end

    // Read multiplexer over the decoded region.
    always_comb begin
        rd_word = 32'h0;
        for (int i = 0; i < MAXW; i++) begin
            if (dec_idx == IDX_W'(i)) begin
                case (dec_rg)
                    RG_ENTRY: if (i < NUM_HARTS)  rd_word = ent_w[i];
                    RG_CODE:  if (i < CODE_WORDS) rd_word = code_w[i];
                    RG_PBUF:  if (i < PBUF_WORDS) rd_word = pbuf_w[i];
                    RG_EXC:   if (i < NUM_HARTS)  rd_word = exc_w[i];
                    default:  rd_word = 32'h0;
                endcase
            end
        end
    end

    dbgmem_track #(.NUM_HARTS(NUM_HARTS), .IDX_W(IDX_W)) u_track (
        .clk(clk), .rst_n(rst_n),
        .entry_rd(ent_rd), .entry_idx(dec_idx), .sel_is_self(sel_word == JAL_SELF),
        .exc_rd(exc_rd), .err_none(err_none), .other_acc(other_acc),
        .pend_we(pend_we), .pend_data(pend_data),
        .halted(halted), .busy_clr(busy_clr), .exc_err(exc_err),
        .lazy_we(lazy_we), .lazy_data(lazy_data)
    );

    // Registered response, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= 32'h0;
        end else begin
            rsp_valid <= req;
            rsp_err   <= req && acc_err;
            rsp_rdata <= (req && !we && !acc_err) ? rd_word : 32'h0;
        end
    end

    // R11: each request yields exactly one response, one cycle later.
    assert_rsp_follows_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rsp_valid == $past(req)));

    // R7: writes to read-only regions are refused.
    assert_ro_store_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && (dec_rg == RG_ENTRY || dec_rg == RG_CODE || dec_rg == RG_EXC))
        |=> rsp_err);

    // R3: completion pulse only rides on a good response.
    assert_busy_with_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_clr |-> (rsp_valid && !rsp_err));

    // R5: exception pulse only rides on a good response.
    assert_exc_with_rsp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        exc_err |-> (rsp_valid && !rsp_err));

    // R8: error responses carry no data.
    assert_err_no_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == 32'h0));
endmodule

// File: tb/dbgmem_slave_tb_top.sv
module dbgmem_slave_tb_top;
    localparam logic [31:0] SELF = 32'h0000_006F;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req, we;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [3:0]  be;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic [1:0]  sel_hart;
    logic        err_none;
    logic        patch_we;
    logic [1:0]  patch_tgt;
    logic [2:0]  patch_idx;
    logic [31:0] patch_data;
    logic        pend_we;
    logic [31:0] pend_data;
    logic [3:0]  halted;
    logic        busy_clr, exc_err;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Reference model state.
    logic [31:0] m_ent [4];
    logic [31:0] m_code [2];
    logic [31:0] m_pbuf [8];
    logic [31:0] m_exc [4];
    logic [3:0]  m_halt;
    logic [31:0] m_pend;
    bit          m_mark;

    always #10 clk = ~clk;

    dbgmem_slave dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .be(be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err), .sel_hart(sel_hart), .err_none(err_none),
        .patch_we(patch_we), .patch_tgt(patch_tgt), .patch_idx(patch_idx),
        .patch_data(patch_data), .pend_we(pend_we), .pend_data(pend_data),
        .halted(halted), .busy_clr(busy_clr), .exc_err(exc_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Region codes: 0 none, 1 entry, 2 code, 3 program buffer, 4 exception.
    function automatic void bdecode(input logic [11:0] a, output int rg, output int ix);
        rg = 0; ix = 0;
        if (a[1:0] != 2'b00) return;
        if (a >= 12'h100 && a < 12'h110) begin rg = 1; ix = (a - 12'h100) / 4; end
        if (a >= 12'h200 && a < 12'h208) begin rg = 2; ix = (a - 12'h200) / 4; end
        if (a >= 12'h300 && a < 12'h320) begin rg = 3; ix = (a - 12'h300) / 4; end
        if (a >= 12'h400 && a < 12'h410) begin rg = 4; ix = (a - 12'h400) / 4; end
    endfunction

    task automatic idle_in();
        req = 0; we = 0; addr = 0; wdata = 0; be = 0;
        patch_we = 0; patch_tgt = 2'd3; patch_idx = 0; patch_data = 0;
        pend_we = 0; pend_data = 0;
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin m_ent[i] = SELF; m_exc[i] = 0; end
        for (int i = 0; i < 2; i++) m_code[i] = 0;
        for (int i = 0; i < 8; i++) m_pbuf[i] = 0;
        m_halt = 0; m_pend = SELF; m_mark = 0;
    endtask

    // Apply the inputs set at this falling edge for one cycle and compare.
    task automatic step();
        int rg, ix;
        logic e_err, e_busy, e_exc, lazy, erd;
        logic [31:0] e_rd;
        bdecode(addr, rg, ix);
        e_err  = req && (rg == 0 || (we && rg != 3));
        e_rd   = 0;
        if (req && !we && !e_err) begin
            case (rg)
                1: e_rd = m_ent[ix];
                2: e_rd = m_code[ix];
                3: e_rd = m_pbuf[ix];
                default: e_rd = m_exc[ix];
            endcase
        end
        erd    = req && !we && rg == 1;
        e_busy = erd && m_ent[sel_hart] == SELF;
        e_exc  = req && !we && rg == 4 && err_none;
        lazy   = req && rg != 1 && m_mark;
        // State update in the order the requirements give.
        if (erd) m_halt[ix] = 1'b1;
        if (lazy) m_ent[sel_hart] = m_pend;
        if (patch_we && patch_tgt == 2'd0 && patch_idx < 4) m_ent[patch_idx] = patch_data;
        if (patch_we && patch_tgt == 2'd1 && patch_idx < 2) m_code[patch_idx] = patch_data;
        if (patch_we && patch_tgt == 2'd2 && patch_idx < 4) m_exc[patch_idx] = patch_data;
        if (req && we && rg == 3)
            for (int k = 0; k < 4; k++)
                if (be[k]) m_pbuf[ix][8*k +: 8] = wdata[8*k +: 8];
        if (lazy) m_pend = SELF;
        if (pend_we) m_pend = pend_data;
        if (erd) m_mark = 1;
        else if (lazy) m_mark = 0;
        @(posedge clk);
        @(negedge clk);
        chk(rsp_valid == req, "R11 rsp_valid", {31'b0, rsp_valid}, {31'b0, req});
        chk(rsp_err == e_err, "R8 rsp_err", {31'b0, rsp_err}, {31'b0, e_err});
        chk(rsp_rdata == e_rd, "R11 rsp_rdata", rsp_rdata, e_rd);
        chk(busy_clr == e_busy, "R3 busy_clr", {31'b0, busy_clr}, {31'b0, e_busy});
        chk(exc_err == e_exc, "R5 exc_err", {31'b0, exc_err}, {31'b0, e_exc});
        chk(halted == m_halt, "R2 halted", {28'b0, halted}, {28'b0, m_halt});
    endtask

    task automatic rd(input logic [11:0] a);
        idle_in(); req = 1; addr = a; step();
    endtask

    task automatic expect_rd(input logic [11:0] a, input logic [31:0] v, input string tag);
        idle_in(); req = 1; addr = a; step();
        chk(rsp_rdata == v, tag, rsp_rdata, v);
    endtask

    initial begin
        void'($urandom(32'd7321));
        model_reset();
        idle_in(); sel_hart = 0; err_none = 1; rst_n = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1: reset state.
        chk(halted == 4'b0, "R1 halted after reset", {28'b0, halted}, 32'h0);
        chk(rsp_valid == 1'b0, "R1 no response after reset", {31'b0, rsp_valid}, 32'h0);
        sel_hart = 2;
        expect_rd(12'h108, SELF, "R1 entry word reset");
        expect_rd(12'h204, 32'h0, "R1 code word reset");
        expect_rd(12'h31C, 32'h0, "R1 program buffer reset");
        expect_rd(12'h40C, 32'h0, "R1 exception word reset");

        // R9 / R4: patch entry 1, set pending, fetch, then leave entry region.
        sel_hart = 1;
        idle_in(); patch_we = 1; patch_tgt = 2'd0; patch_idx = 1; patch_data = 32'hAAAA_0001;
        pend_we = 1; pend_data = 32'h1234_5678; step();
        rd(12'h108);               // entry fetch, no completion: sel entry not self
        rd(12'h200);               // first outside access: rewrite
        rd(12'h204);               // second outside access: no rewrite
        expect_rd(12'h104, 32'h1234_5678, "R4 entry rewritten with pending");
        rd(12'h300);               // consumes mark again with pending = self
        expect_rd(12'h104, SELF, "R4 pending returned to self");

        // R9: patch wins over a same-cycle rewrite of the same entry word.
        sel_hart = 3;
        idle_in(); pend_we = 1; pend_data = 32'h0000_5555; step();
        rd(12'h100);
        idle_in(); req = 1; addr = 12'h200; patch_we = 1; patch_tgt = 2'd0;
        patch_idx = 3; patch_data = 32'hBEEF_0003; step();
        expect_rd(12'h10C, 32'hBEEF_0003, "R9 patch beats rewrite");

        // R10: pending load coinciding with a rewrite.
        idle_in(); pend_we = 1; pend_data = 32'h0000_1111; step();
        rd(12'h100);
        idle_in(); req = 1; addr = 12'h400; pend_we = 1; pend_data = 32'h0000_2222; step();
        expect_rd(12'h10C, 32'h0000_1111, "R10 old pending reaches entry");
        rd(12'h300);
        expect_rd(12'h10C, 32'h0000_2222, "R10 new pending kept");

        // R5: exception fetch with and without a recorded error.
        idle_in(); patch_we = 1; patch_tgt = 2'd2; patch_idx = 2; patch_data = 32'hE0E0_0002; step();
        err_none = 1; expect_rd(12'h408, 32'hE0E0_0002, "R5 exception word");
        err_none = 0; rd(12'h408);
        err_none = 1;

        // R7: store to a read-only region leaves it unchanged.
        idle_in(); req = 1; we = 1; addr = 12'h204; wdata = 32'hDEAD_BEEF; be = 4'hF; step();
        chk(rsp_err == 1'b1, "R7 store to code refused", {31'b0, rsp_err}, 32'h1);
        expect_rd(12'h204, 32'h0, "R7 code unchanged");

        // R8: misaligned and unmapped.
        rd(12'h302);
        rd(12'hF00);

        // R6: byte lanes.
        idle_in(); req = 1; we = 1; addr = 12'h308; wdata = 32'h1122_3344; be = 4'hF; step();
        idle_in(); req = 1; we = 1; addr = 12'h308; wdata = 32'hAABB_CCDD; be = 4'b0101; step();
        expect_rd(12'h308, 32'h11BB_33DD, "R6 byte lanes");

        // Random mix.
        for (int n = 0; n < 5000; n++) begin
            int r;
            idle_in();
            sel_hart = 2'($urandom % 4);
            err_none = 1'($urandom % 2);
            r = $urandom % 10;
            req = ($urandom % 8) != 0;
            we  = ($urandom % 10) < 3;
            be  = 4'($urandom);
            wdata = $urandom;
            case (r)
                0, 1: addr = 12'h100 + 12'(4 * ($urandom % 4));
                2:    addr = 12'h200 + 12'(4 * ($urandom % 2));
                5:    addr = 12'h400 + 12'(4 * ($urandom % 4));
                6:    addr = 12'h300 + 12'(1 + $urandom % 3);
                7:    addr = 12'($urandom);
                default: addr = 12'h300 + 12'(4 * ($urandom % 8));
            endcase
            if ($urandom % 6 == 0) begin
                patch_we = 1; patch_tgt = 2'($urandom % 4);
                patch_idx = 3'($urandom % 4); patch_data = $urandom;
                if ($urandom % 3 == 0) begin patch_data = SELF; patch_idx = 3'(sel_hart); end
            end
            if ($urandom % 6 == 0) begin
                pend_we = 1; pend_data = ($urandom % 2) ? SELF : $urandom;
            end
            step();
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule